// File: doc/BRIEF.md
# Byte and Word Load-Store Unit

This unit sits between the execute stage of a 16-bit processor and a 16-bit-wide synchronous memory whose addresses count bytes. A request carries a byte address, a direction (load or store), a size (byte or word) and, for stores, write data. The unit turns each request into a single memory command with per-byte write enables. For a load, it returns a full 16-bit value.

Byte lanes are little-endian: the lowest address bit chooses the low lane (0) or the high lane (1). A byte store writes only the chosen lane and puts the byte on both lanes of the write bus. A byte load picks the chosen lane and sign-extends it. Word accesses clear the lowest address bit and move the whole word.

The unit handles one request at a time. A request is taken only while `req_ready` is high. The memory command goes out in the cycle after acceptance. Read data arrives one cycle later, and `done` pulses in the cycle after that.

Top module: `bytelane_lsu`

## Requirements
- R1: While reset is applied and in the first cycle after it, req_ready is 1 and done, mem_en and mem_we are all 0. A reset applied during a transfer abandons it.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. mem_en is then 1 for exactly the one following cycle.
- R3: While mem_en is 1, mem_addr equals the accepted address with bit 0 cleared. All other bits are passed through unchanged.
- R4: For a word store, mem_we is 2'b11 and mem_wdata equals the request data.
- R5: For a byte store, mem_we is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1. mem_wdata is the low data byte repeated on both lanes. The other byte of the memory word is left unchanged.
- R6: A word load returns the full memory word, whatever the value of address bit 0.
- R7: A byte load returns bits 7:0 of the memory word when address bit 0 is 0, and bits 15:8 when it is 1. Bit 7 of the selected byte is copied into rdata bits 15:8.
- R8: done is high for exactly one cycle, two cycles after the cycle in which mem_en is high. For a load, rdata holds the result in that cycle.
- R9: req_ready is 0 from the cycle after acceptance until done has fallen. Requests presented during that time are ignored: they produce no memory command and change no memory contents.
- R10: A load never asserts any bit of mem_we.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte size, 0 = word size |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Store data (byte stores use bits 7:0) |
| req_ready | output | 1 | Unit idle, request will be taken |
| mem_en | output | 1 | Memory command strobe |
| mem_we | output | 2 | Per-lane write enable, bit 0 = bits 7:0 |
| mem_addr | output | 16 | Word-aligned byte address |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after mem_en |
| done | output | 1 | Transfer complete pulse |
| rdata | output | 16 | Load result, valid with done |

## Verification
Each internal fault shows up at a port within one to three cycles of acceptance. A controller stuck out of idle keeps req_ready low. A skipped or repeated state moves the done pulse or doubles mem_en. A corrupted held request changes mem_addr or mem_we in the issue cycle. A lane or extension error shows up in rdata during done. A wrong lane enable changes the neighbouring byte, which the next word load of that address reveals.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } lsu_state_e;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_BYTE = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic                is_store;
        acc_size_e           size;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   wdata;
    } lsu_req_t;

    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:LSEL_W], {LSEL_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
        return {{(WORD_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
    import lsu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  lsu_req_t req_in,
    output logic     ready,
    output logic     issue,
    output logic     capture,
    output logic     done,
    output lsu_req_t held
);
    lsu_state_e state_q, state_d;
    logic       accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            held    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) held <= req_in;
        end
    end

    assign ready   = (state_q == ST_IDLE);
    assign issue   = (state_q == ST_ISSUE);
    assign capture = (state_q == ST_WAIT);
    assign done    = (state_q == ST_DONE);

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(ready)) |-> $stable(held)); // R9
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $countones({ready, issue, capture, done}) == 1); // R2
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_pkg::*;
(
    input  logic              issue,
    input  logic              is_store,
    input  acc_size_e         size,
    input  logic [LSEL_W-1:0] lane_sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [LANES-1:0]  mem_we,
    output logic [WORD_W-1:0] mem_wdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            mem_we[g] = issue && is_store &&
                        ((size == SZ_WORD) || (lane_sel == LSEL_W'(g)));
            mem_wdata[g*BYTE_W +: BYTE_W] = (size == SZ_BYTE) ?
                        wdata[BYTE_W-1:0] : wdata[g*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        if (issue && is_store && size == SZ_BYTE)
            AST_BYTE_ONE_LANE: assert ($countones(mem_we) == 1); // R5
        if (!is_store)
            AST_LOAD_NO_WE: assert (mem_we == '0); // R10
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              is_store,
    input  acc_size_e         size,
    input  logic [LSEL_W-1:0] lane_sel,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] rdata
);
    logic [BYTE_W-1:0] lane_byte [LANES];
    logic [BYTE_W-1:0] picked;
    logic [WORD_W-1:0] result;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_byte[g] = mem_rdata[g*BYTE_W +: BYTE_W];
    end

    assign picked = lane_byte[lane_sel];
    assign result = (size == SZ_BYTE) ? sext_byte(picked) : mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture && !is_store) begin
            rdata <= result;
        end
    end

    AST_BYTE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (capture && !is_store && size == SZ_BYTE) |=>
            rdata[WORD_W-1:BYTE_W] == {(WORD_W-BYTE_W){rdata[BYTE_W-1]}}); // R7
endmodule

// File: rtl/bytelane_lsu.sv
module bytelane_lsu
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_byte,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              mem_en,
    output logic [LANES-1:0]  mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] rdata
);
    lsu_req_t req_in, held;
    logic     issue, capture;

    always_comb begin
        req_in.is_store = req_store;
        req_in.size     = req_byte ? SZ_BYTE : SZ_WORD;
        req_in.addr     = req_addr;
        req_in.wdata    = req_wdata;
    end

    lsu_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .ready     (req_ready),
        .issue     (issue),
        .capture   (capture),
        .done      (done),
        .held      (held)
    );

    lsu_store_steer u_steer (
        .issue     (issue),
        .is_store  (held.is_store),
        .size      (held.size),
        .lane_sel  (held.addr[LSEL_W-1:0]),
        .wdata     (held.wdata),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    lsu_load_extract u_extract (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .is_store  (held.is_store),
        .size      (held.size),
        .lane_sel  (held.addr[LSEL_W-1:0]),
        .mem_rdata (mem_rdata),
        .rdata     (rdata)
    );

    assign mem_en   = issue;
    assign mem_addr = align_addr(held.addr);

    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> !mem_en); // R2
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (mem_addr[0] == 1'b0)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> ##1 done); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R9
    AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (mem_we == '0)); // R9
endmodule

// File: tb/test_bytelane_lsu.sv
module test_bytelane_lsu;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store, req_byte;
    logic [15:0] req_addr, req_wdata;
    logic        req_ready, mem_en, done;
    logic [1:0]  mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, rdata;

    int checks = 0;
    int fails  = 0;
    int en_count = 0;
    logic [15:0] ram [0:255];
    logic [7:0]  shadow [0:511];

    always #2.5 clk = ~clk;

    bytelane_lsu i_bytelane_lsu (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .rdata(rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) ram[i] <= 16'h0000;
            mem_rdata <= 16'h0000;
        end else if (mem_en) begin
            if (mem_we[0]) ram[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
            if (mem_we[1]) ram[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
            mem_rdata <= ram[mem_addr[8:1]];
        end
        if (!rst && mem_en) en_count <= en_count + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic        byt;
        logic [15:0] addr;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 16'h0010, 16'hA55A},
        '{1'b0, 1'b0, 16'h0010, 16'h0000},
        '{1'b0, 1'b0, 16'h0011, 16'h0000},
        '{1'b0, 1'b1, 16'h0010, 16'h0000},
        '{1'b0, 1'b1, 16'h0011, 16'h0000},
        '{1'b1, 1'b1, 16'h0021, 16'h1280},
        '{1'b0, 1'b0, 16'h0020, 16'h0000},
        '{1'b1, 1'b1, 16'h0020, 16'h0037},
        '{1'b0, 1'b0, 16'h0021, 16'h0000},
        '{1'b0, 1'b1, 16'h0021, 16'h0000},
        '{1'b0, 1'b1, 16'h0020, 16'h0000},
        '{1'b1, 1'b0, 16'h0031, 16'h7F01},
        '{1'b0, 1'b0, 16'h0030, 16'h0000},
        '{1'b0, 1'b1, 16'h0031, 16'h0000},
        '{1'b1, 1'b1, 16'h0031, 16'hFFFE},
        '{1'b0, 1'b0, 16'h0030, 16'h0000},
        '{1'b1, 1'b1, 16'hF0A4, 16'h00C3},
        '{1'b0, 1'b0, 16'hF0A5, 16'h0000}
    };

    // One complete transfer; noise keeps a conflicting request active while busy
    task automatic do_op(input logic wr, input logic byt, input logic [15:0] addr,
                         input logic [15:0] data, input bit noise);
        logic [15:0] exp_rd;
        logic [1:0]  exp_we;
        logic [15:0] exp_wd;
        logic [8:0]  lo;
        int          en0;
        lo = {addr[8:1], 1'b0};
        if (byt) exp_rd = {{8{shadow[addr[8:0]][7]}}, shadow[addr[8:0]]};
        else     exp_rd = {shadow[lo + 9'd1], shadow[lo]};
        exp_we = !wr ? 2'b00 : (!byt ? 2'b11 : (addr[0] ? 2'b10 : 2'b01));
        exp_wd = byt ? {data[7:0], data[7:0]} : data;
        en0 = en_count;
        chk(req_ready === 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_store = wr; req_byte = byt; req_addr = addr; req_wdata = data;
        @(negedge clk);
        if (noise) begin
            req_store = 1'b1; req_byte = 1'b0; req_addr = 16'h0090; req_wdata = 16'hDEAD;
        end else begin
            req_valid = 1'b0;
        end
        chk(mem_en === 1'b1, "R2 mem_en in issue cycle", 32'(mem_en), 32'd1);
        chk(mem_addr === {addr[15:1], 1'b0}, "R3 aligned address", 32'(mem_addr), 32'({addr[15:1], 1'b0}));
        chk(mem_we === exp_we, wr ? (byt ? "R5 byte lane enable" : "R4 word enables") : "R10 load enables",
            32'(mem_we), 32'(exp_we));
        if (wr) chk(mem_wdata === exp_wd, byt ? "R5 replicated byte" : "R4 word data",
                    32'(mem_wdata), 32'(exp_wd));
        chk(req_ready === 1'b0, "R9 busy in issue", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk(mem_en === 1'b0 && done === 1'b0, "R2 single strobe, no early done",
            32'({mem_en, done}), 32'd0);
        chk(req_ready === 1'b0, "R9 busy in wait", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk(done === 1'b1, "R8 done timing", 32'(done), 32'd1);
        chk(req_ready === 1'b0, "R9 busy in done", 32'(req_ready), 32'd0);
        if (!wr) chk(rdata === exp_rd, byt ? "R7 byte load value" : "R6 word load value",
                     32'(rdata), 32'(exp_rd));
        req_valid = 1'b0;
        @(negedge clk);
        chk(done === 1'b0, "R8 done single pulse", 32'(done), 32'd0);
        chk(req_ready === 1'b1, "R9 idle again", 32'(req_ready), 32'd1);
        chk(en_count - en0 == 1, "R9 one command per transfer", 32'(en_count - en0), 32'd1);
        if (wr) begin
            if (byt) shadow[addr[8:0]] = data[7:0];
            else begin
                shadow[lo] = data[7:0];
                shadow[lo + 9'd1] = data[15:8];
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) shadow[i] = 8'h00;
        rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_byte = 1'b0;
        req_addr = 16'h0000; req_wdata = 16'h0000;
        repeat (3) @(negedge clk);
        // R1 reset state during reset
        chk(req_ready === 1'b1 && done === 1'b0 && mem_en === 1'b0 && mem_we === 2'b00,
            "R1 reset outputs", 32'({req_ready, done, mem_en, mem_we}), 32'h10);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1 && done === 1'b0 && mem_en === 1'b0,
            "R1 after reset", 32'({req_ready, done, mem_en}), 32'h4);

        for (int v = 0; v < NV; v++)
            do_op(VECS[v].wr, VECS[v].byt, VECS[v].addr, VECS[v].data, 1'b0);

        // R9: conflicting store held on req_valid during a busy transfer
        do_op(1'b1, 1'b0, 16'h0040, 16'h1234, 1'b1);
        do_op(1'b0, 1'b0, 16'h0090, 16'h0000, 1'b0);
        do_op(1'b0, 1'b0, 16'h0040, 16'h0000, 1'b0);

        // R5: neighbouring byte kept after byte store to low lane
        do_op(1'b1, 1'b1, 16'h0040, 16'h00EE, 1'b0);
        do_op(1'b0, 1'b1, 16'h0041, 16'h0000, 1'b0);

        // R1: reset in the middle of a transfer abandons it
        req_valid = 1'b1; req_store = 1'b0; req_byte = 1'b0; req_addr = 16'h0010;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && mem_en === 1'b0 && done === 1'b0,
            "R1 mid-transfer reset", 32'({req_ready, mem_en, done}), 32'h4);
        rst = 1'b0;
        for (int i = 0; i < 512; i++) shadow[i] = 8'h00;
        @(negedge clk);
        chk(done === 1'b0, "R1 no done after reset", 32'(done), 32'd0);
        do_op(1'b0, 1'b0, 16'h0010, 16'h0000, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule